// File: doc/BRIEF.md
# Soft-Hint Feedback ACK Interceptor

This block sits between a receive PHY and a CSMA MAC as a transparent streaming shim. On the upward path every beat carries eight decoded data bits together with eight 9-bit confidence hints, one per bit. The shim forwards each beat to the MAC unchanged and in the same cycle. While the beat passes, the shim adds the eight hints into a running per-packet total. When a beat marked end-of-packet passes, that total becomes the stored channel-quality feedback value.

On the downward path the MAC streams its outgoing frames one byte per cycle. When the frame is an acknowledgment, the shim overwrites a fixed window of payload bytes with the stored feedback value as the bytes pass. It adds no register stage. The MAC does not need to know that the feedback exists. CRC checking, the decision to acknowledge, and MAC timing stay outside the block.

Top module: `shack_top`

## Requirements
- R1: Upward data, hints, valid, start and end flags appear on the upward outputs in the same cycle, bit for bit unchanged.
- R2: A valid beat with the start flag set restarts the running total at that beat's own hint sum, discarding the old total.
- R3: The running total is 20 bits wide and unsigned. It saturates at 0xFFFFF instead of wrapping.
- R4: The feedback value is loaded only on a valid end-of-packet beat, with the total including that beat. Otherwise it holds, including while a later packet is in progress.
- R5: Downward valid and frame-start flags pass through in the same cycle. Bytes outside the feedback window pass unchanged.
- R6: In a frame whose acknowledgment flag is high on its first byte, the bytes at offsets 4, 5 and 6 (offset 0 is the first byte) are replaced by the feedback value, least significant byte first. The top 4 bits of the third byte are zero.
- R7: A frame whose acknowledgment flag is low on its first byte passes fully unmodified.
- R8: The feedback patched into a frame is the value stored when that frame's first byte passed. A packet ending during the frame does not change it.
- R9: After reset the running total and the feedback value are zero.
- R10: Upward cycles with valid low change neither the total nor the feedback, whatever their other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_in_valid | input | 1 | PHY beat valid |
| up_in_sop | input | 1 | First beat of a received packet |
| up_in_eop | input | 1 | Last beat of a received packet |
| up_in_data | input | 8 | Decoded data bits |
| up_in_hint | input | 72 | Eight 9-bit hints, lane i at bits 9i+8..9i |
| up_out_valid | output | 1 | Beat valid toward MAC |
| up_out_sop | output | 1 | Start flag toward MAC |
| up_out_eop | output | 1 | End flag toward MAC |
| up_out_data | output | 8 | Data toward MAC |
| up_out_hint | output | 72 | Hints toward MAC |
| tx_in_valid | input | 1 | MAC transmit byte valid |
| tx_in_sof | input | 1 | First byte of a transmit frame |
| tx_in_is_ack | input | 1 | Frame is an acknowledgment, sampled with the first byte |
| tx_in_byte | input | 8 | MAC transmit byte |
| tx_out_valid | output | 1 | Byte valid toward transmitter |
| tx_out_sof | output | 1 | Frame start toward transmitter |
| tx_out_byte | output | 8 | Possibly patched byte toward transmitter |

## Verification
The upward path is driven with random hint patterns, idle cycles that carry garbage hints, and packets that start before an acknowledgment has been sent. These patterns tell apart a correct per-packet restart from stale accumulation, and a correct end-of-packet capture from a running value. A long run of all-maximum hints separates saturation from wraparound. Acknowledgment frames are interleaved with non-acknowledgment frames. One acknowledgment overlaps a packet end, to show that the frame uses the value captured at its first byte.

// File: rtl/shack_pkg.sv
package shack_pkg;

    localparam int unsigned BYTE_W = 8;

    // number of whole bytes needed to carry a value of the given width
    function automatic int unsigned bytes_for(input int unsigned width);
        return (width + BYTE_W - 1) / BYTE_W;
    endfunction

    // width needed to hold the sum of n unsigned values of width w
    function automatic int unsigned sum_width(input int unsigned w, input int unsigned n);
        return w + $clog2(n);
    endfunction

endpackage

// File: rtl/shack_lane_sum.sv
module shack_lane_sum
    import shack_pkg::*;
#(
    parameter int unsigned LANES  = 8,
    parameter int unsigned HINT_W = 9,
    localparam int unsigned SUM_W = sum_width(HINT_W, LANES)
) (
    input  logic [LANES*HINT_W-1:0] hints,
    output logic [SUM_W-1:0]        total
);

    logic [HINT_W-1:0] lane [LANES];

    // unpack the flat hint bus into one element per data bit
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = hints[g*HINT_W +: HINT_W];
    end

    always_comb begin
        total = '0;
        for (int i = 0; i < LANES; i++) begin
            total = total + SUM_W'(lane[i]);
        end
    end

endmodule

// File: rtl/shack_accum.sv
module shack_accum
    import shack_pkg::*;
#(
    parameter int unsigned LANES  = 8,
    parameter int unsigned HINT_W = 9,
    parameter int unsigned ACC_W  = 20,
    localparam int unsigned SUM_W = sum_width(HINT_W, LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_valid,
    input  logic             beat_sop,
    input  logic             beat_eop,
    input  logic [SUM_W-1:0] beat_sum,
    output logic [ACC_W-1:0] acc,
    output logic [ACC_W-1:0] fb
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] fb;
    } acc_st_t;

    acc_st_t st_d, st_q;

    logic [ACC_W:0]   base_ext;
    logic [ACC_W:0]   sum_ext;
    logic [ACC_W-1:0] next_total;

    always_comb begin
        st_d     = st_q;
        // a start beat begins from zero, otherwise continue the packet total
        base_ext = beat_sop ? '0 : {1'b0, st_q.acc};
        sum_ext  = base_ext + (ACC_W+1)'(beat_sum);
        if (sum_ext[ACC_W]) begin
            next_total = '1;
        end else begin
            next_total = sum_ext[ACC_W-1:0];
        end
        if (beat_valid) begin
            st_d.acc = next_total;
            if (beat_eop) begin
                st_d.fb = next_total;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc = st_q.acc;
    assign fb  = st_q.fb;

endmodule

// File: rtl/shack_patcher.sv
module shack_patcher
    import shack_pkg::*;
#(
    parameter int unsigned ACC_W  = 20,
    parameter int unsigned FB_OFS = 4,
    parameter int unsigned CNT_W  = 8,
    localparam int unsigned FB_BYTES = bytes_for(ACC_W),
    localparam int unsigned PAD_W    = FB_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  fb,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_is_ack,
    input  logic [BYTE_W-1:0] in_byte,
    output logic [BYTE_W-1:0] out_byte,
    output logic              frame_ack,
    output logic [ACC_W-1:0]  snap
);

    localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             in_ack;
        logic [ACC_W-1:0] snap;
    } pat_st_t;

    pat_st_t st_d, st_q;

    logic [CNT_W-1:0]  offset;
    logic [ACC_W-1:0]  fb_use;
    logic [PAD_W-1:0]  fb_pad;
    logic [BYTE_W-1:0] fb_byte [FB_BYTES];
    logic              in_window;
    logic [BYTE_W-1:0] sel_byte;

    // offset and frame type of the byte on the input this cycle
    assign offset    = in_sof ? '0 : st_q.cnt;
    assign frame_ack = in_sof ? in_is_ack : st_q.in_ack;
    assign fb_use    = in_sof ? fb : st_q.snap;
    assign fb_pad    = PAD_W'(fb_use);

    for (genvar g = 0; g < FB_BYTES; g++) begin : g_fbyte
        assign fb_byte[g] = fb_pad[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        in_window = 1'b0;
        sel_byte  = in_byte;
        for (int i = 0; i < FB_BYTES; i++) begin
            if (32'(offset) == FB_OFS + i) begin
                in_window = 1'b1;
                sel_byte  = fb_byte[i];
            end
        end
    end

    assign out_byte = (in_valid && frame_ack && in_window) ? sel_byte : in_byte;

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            if (in_sof) begin
                st_d.in_ack = in_is_ack;
                st_d.snap   = fb;
            end
            if (32'(offset) == CNT_MAX) begin
                st_d.cnt = offset;
            end else begin
                st_d.cnt = offset + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign snap = st_q.snap;

endmodule

// File: rtl/shack_top.sv
module shack_top
    import shack_pkg::*;
#(
    parameter int unsigned LANES  = 8,
    parameter int unsigned HINT_W = 9,
    parameter int unsigned ACC_W  = 20,
    parameter int unsigned FB_OFS = 4,
    parameter int unsigned CNT_W  = 8,
    localparam int unsigned HBUS_W = LANES * HINT_W,
    localparam int unsigned SUM_W  = sum_width(HINT_W, LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_in_valid,
    input  logic              up_in_sop,
    input  logic              up_in_eop,
    input  logic [LANES-1:0]  up_in_data,
    input  logic [HBUS_W-1:0] up_in_hint,
    output logic              up_out_valid,
    output logic              up_out_sop,
    output logic              up_out_eop,
    output logic [LANES-1:0]  up_out_data,
    output logic [HBUS_W-1:0] up_out_hint,
    input  logic              tx_in_valid,
    input  logic              tx_in_sof,
    input  logic              tx_in_is_ack,
    input  logic [BYTE_W-1:0] tx_in_byte,
    output logic              tx_out_valid,
    output logic              tx_out_sof,
    output logic [BYTE_W-1:0] tx_out_byte
);

    logic [SUM_W-1:0] beat_sum;
    logic [ACC_W-1:0] acc_w;
    logic [ACC_W-1:0] fb_w;
    logic [ACC_W-1:0] snap_w;
    logic             frame_ack_w;

    // upward path: observation only, no register stage
    assign up_out_valid = up_in_valid;
    assign up_out_sop   = up_in_sop;
    assign up_out_eop   = up_in_eop;
    assign up_out_data  = up_in_data;
    assign up_out_hint  = up_in_hint;

    shack_lane_sum #(
        .LANES  (LANES),
        .HINT_W (HINT_W)
    ) u_sum (
        .hints (up_in_hint),
        .total (beat_sum)
    );

    shack_accum #(
        .LANES  (LANES),
        .HINT_W (HINT_W),
        .ACC_W  (ACC_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (up_in_valid),
        .beat_sop   (up_in_sop),
        .beat_eop   (up_in_eop),
        .beat_sum   (beat_sum),
        .acc        (acc_w),
        .fb         (fb_w)
    );

    shack_patcher #(
        .ACC_W  (ACC_W),
        .FB_OFS (FB_OFS),
        .CNT_W  (CNT_W)
    ) u_pat (
        .clk       (clk),
        .rst_n     (rst_n),
        .fb        (fb_w),
        .in_valid  (tx_in_valid),
        .in_sof    (tx_in_sof),
        .in_is_ack (tx_in_is_ack),
        .in_byte   (tx_in_byte),
        .out_byte  (tx_out_byte),
        .frame_ack (frame_ack_w),
        .snap      (snap_w)
    );

    // downward path flags: same cycle
    assign tx_out_valid = tx_in_valid;
    assign tx_out_sof   = tx_in_sof;

endmodule

// File: rtl/shack_chk.sv
module shack_chk #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned HINT_W = 9,
    parameter int unsigned ACC_W  = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up_in_valid,
    input logic             up_in_sop,
    input logic             up_in_eop,
    input logic             tx_in_valid,
    input logic             tx_in_sof,
    input logic [7:0]       tx_in_byte,
    input logic [7:0]       tx_out_byte,
    input logic [ACC_W-1:0] acc,
    input logic [ACC_W-1:0] fb,
    input logic [ACC_W-1:0] snap,
    input logic             frame_ack
);

    localparam logic [ACC_W-1:0] BEAT_MAX = ACC_W'(LANES * ((1 << HINT_W) - 1));

    // R3: without a restart the total never goes down (saturates, no wrap)
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (up_in_valid && !up_in_sop) |=> (acc >= $past(acc)));

    // R2: a start beat leaves at most one beat's worth in the total
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (up_in_valid && up_in_sop) |=> (acc <= BEAT_MAX));

    // R4: feedback changes only through a valid end beat
    a_r4_fb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_in_valid && up_in_eop) |=> $stable(fb));

    // R4: after an end beat the feedback equals the packet total
    a_r4_fb_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (up_in_valid && up_in_eop) |=> (fb == acc));

    // R10: idle upward cycles leave the total alone
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !up_in_valid |=> $stable(acc));

    // R8: the frame's feedback copy only moves at a frame start
    a_r8_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_in_valid && tx_in_sof) |=> $stable(snap));

    // R7: bytes of a non-acknowledgment frame pass untouched
    a_r7_nonack: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_in_valid && !frame_ack) |-> (tx_out_byte == tx_in_byte));

    // R9: cleared state when reset is released
    a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fb == '0 && acc == '0));

endmodule

bind shack_top shack_chk #(
    .LANES  (LANES),
    .HINT_W (HINT_W),
    .ACC_W  (ACC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .up_in_valid (up_in_valid),
    .up_in_sop   (up_in_sop),
    .up_in_eop   (up_in_eop),
    .tx_in_valid (tx_in_valid),
    .tx_in_sof   (tx_in_sof),
    .tx_in_byte  (tx_in_byte),
    .tx_out_byte (tx_out_byte),
    .acc         (acc_w),
    .fb          (fb_w),
    .snap        (snap_w),
    .frame_ack   (frame_ack_w)
);

// File: tb/sim_shack_top.sv
module sim_shack_top;

    localparam int CLK_PERIOD = 10;
    localparam int OFS        = 4;
    localparam int SAT        = 1048575;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        u_v = 1'b0, u_sop = 1'b0, u_eop = 1'b0;
    logic [7:0]  u_data = '0;
    logic [71:0] u_hint = '0;
    logic        a_v = 1'b0, a_sof = 1'b0, a_ack = 1'b0;
    logic [7:0]  a_byte = '0;
    logic        o_v, o_sop, o_eop;
    logic [7:0]  o_data;
    logic [71:0] o_hint;
    logic        t_v, t_sof;
    logic [7:0]  t_byte;

    int compared = 0;
    int mismatched = 0;
    string tag = "R9";

    // behavioural reference state
    int m_acc = 0, m_fb = 0, m_snap = 0, m_cnt = 0;
    bit m_inack = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shack_top u0 (
        .clk (clk), .rst_n (rst_n),
        .up_in_valid (u_v), .up_in_sop (u_sop), .up_in_eop (u_eop),
        .up_in_data (u_data), .up_in_hint (u_hint),
        .up_out_valid (o_v), .up_out_sop (o_sop), .up_out_eop (o_eop),
        .up_out_data (o_data), .up_out_hint (o_hint),
        .tx_in_valid (a_v), .tx_in_sof (a_sof), .tx_in_is_ack (a_ack),
        .tx_in_byte (a_byte),
        .tx_out_valid (t_v), .tx_out_sof (t_sof), .tx_out_byte (t_byte)
    );

    function automatic int hint_sum(input logic [71:0] h);
        int s = 0;
        for (int i = 0; i < 8; i++) s += int'(h[i*9 +: 9]);
        return s;
    endfunction

    // compare on every falling edge, then advance the model
    always @(negedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_fb = 0; m_snap = 0; m_cnt = 0; m_inack = 0;
        end else begin
            int  off, fbv, exp_b, s;
            bit  isack;
            string rq;
            // R1: upward pass-through
            compared++;
            if ({o_v, o_sop, o_eop, o_data, o_hint} !== {u_v, u_sop, u_eop, u_data, u_hint}) begin
                mismatched++;
                $display("FAIL R1 (%s) up got %h expected %h", tag,
                    {o_v, o_sop, o_eop, o_data, o_hint}, {u_v, u_sop, u_eop, u_data, u_hint});
            end
            // R5: flags pass through
            compared++;
            if ({t_v, t_sof} !== {a_v, a_sof}) begin
                mismatched++;
                $display("FAIL R5 (%s) tx flags got %b expected %b", tag, {t_v, t_sof}, {a_v, a_sof});
            end
            off   = a_sof ? 0 : m_cnt;
            isack = a_sof ? a_ack : m_inack;
            fbv   = a_sof ? m_fb : m_snap;
            exp_b = int'(a_byte);
            rq    = isack ? "R5" : "R7";
            if (isack && off >= OFS && off < OFS + 3) begin
                exp_b = (fbv >> (8 * (off - OFS))) & 255;
                rq    = "R6";
            end
            if (a_v) begin
                compared++;
                if (int'(t_byte) !== exp_b) begin
                    mismatched++;
                    $display("FAIL %s (%s) tx byte at offset %0d got %h expected %h",
                        rq, tag, off, t_byte, exp_b);
                end
                if (a_sof) begin
                    m_snap  = m_fb;
                    m_inack = a_ack;
                end
                m_cnt = (off + 1 > 255) ? 255 : off + 1;
            end
            if (u_v) begin
                s = hint_sum(u_hint);
                m_acc = u_sop ? s : m_acc + s;
                if (m_acc > SAT) m_acc = SAT;
                if (u_eop) m_fb = m_acc;
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        u_v = 0; u_sop = 0; u_eop = 0;
        a_v = 0; a_sof = 0; a_ack = 0;
        u_hint = {$urandom, $urandom, $urandom};
        a_byte = 8'($urandom);
    endtask

    task automatic put_beat(input bit sop, input bit eop, input bit maxed);
        u_v = 1; u_sop = sop; u_eop = eop;
        u_data = 8'($urandom);
        u_hint = maxed ? '1 : {$urandom, $urandom, $urandom};
    endtask

    task automatic put_byte(input bit sof, input bit isack);
        a_v = 1; a_sof = sof; a_ack = isack;
        a_byte = 8'($urandom);
    endtask

    task automatic send_pkt(input int n, input bit maxed, input bit gaps);
        for (int i = 0; i < n; i++) begin
            put_beat(i == 0, i == n - 1, maxed);
            tick();
            if (gaps) tick();
        end
    endtask

    task automatic send_frame(input int n, input bit isack);
        for (int i = 0; i < n; i++) begin
            put_byte(i == 0, isack);
            tick();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R9: feedback zero straight after reset
        tag = "R9";
        send_frame(10, 1);
        // R2 R4 R6: ordinary packet then acknowledgment
        tag = "R2";
        send_pkt(5, 0, 0);
        tag = "R6";
        send_frame(12, 1);
        // R7: non-acknowledgment frame untouched
        tag = "R7";
        send_frame(12, 0);
        // R10: idle cycles with garbage hints between beats
        tag = "R10";
        send_pkt(6, 0, 1);
        send_frame(9, 1);
        // R4: a new packet in progress keeps the previous value
        tag = "R4";
        put_beat(1, 0, 0); tick();
        put_beat(0, 0, 0); tick();
        send_frame(8, 1);
        put_beat(0, 1, 0); tick();
        // R8: packet ends while an acknowledgment frame is in flight
        tag = "R8";
        for (int i = 0; i < 10; i++) begin
            put_byte(i == 0, 1);
            put_beat(i == 1, i == 2, 0);
            tick();
        end
        send_frame(8, 1);
        // R3: long run of maximum hints saturates
        tag = "R3";
        send_pkt(260, 1, 0);
        send_frame(8, 1);
        // R2: next packet restarts from its own sum
        tag = "R2";
        send_pkt(2, 0, 0);
        send_frame(8, 1);
        // mixed random traffic
        tag = "R5";
        for (int k = 0; k < 20; k++) begin
            send_pkt(1 + ($urandom % 4), 0, k[0]);
            send_frame(5 + ($urandom % 6), k[1]);
        end
        repeat (2) tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule